// File: doc/BRIEF.md
# Single-Precision Boxing and Sign-Injection Slice

This block sits beside a 64-bit floating-point register file that also stores 32-bit values. A 32-bit value lives in the low half of a register, and the upper half is filled with ones. Each cycle the block may accept one operation on up to two register values. It checks and strips that upper fill on every 32-bit read. It performs the three sign-injection forms, both directions of the FP/integer move, and write-back of a 32-bit result that an external arithmetic unit produced. Every 32-bit value written to the FP side is stored with the upper fill.

Sign-injection and moves keep a NaN payload bit for bit. An arithmetic result that is a NaN is replaced by the canonical quiet NaN, so no payload survives that path. A register whose upper half is not all ones is never used as a 32-bit operand: the canonical NaN takes its place. Results appear one clock after the request, qualified by an output valid flag.

Top module: `fp_box_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld`, `fp_wb` and `int_wb` become zero at that edge.
- R2: Results are registered. An operation presented with `in_vld` high appears one clock later with `out_vld` high. A cycle with `in_vld` low gives `out_vld`, `fp_wb` and `int_wb` all zero on the next cycle.
- R3: For the sign-injection opcodes (0 = copy sign, 1 = inverted sign, 2 = XOR of signs), an operand whose bits 63:32 are not all ones is replaced by 0x7FC00000 before use. This holds for both `src1` and `src2`.
- R4: Sign injection sets bit 31 of the result to bit 31 of operand 2 (opcode 0), to its inverse (opcode 1) or to the XOR of the bit-31 values of both operands (opcode 2). Bits 30:0 always come from operand 1.
- R5: Every FP-side write (opcodes 0, 1, 2, 4, 5) puts all ones in `fp_wb[63:32]` and drives `int_wb` to zero.
- R6: Opcode 5 writes `arith_res`. If it is a NaN (bits 30:23 all ones and bits 22:0 nonzero), it is replaced by 0x7FC00000. Any other value, infinity included, is written bit-exact.
- R7: Sign injection keeps the payload of a correctly boxed NaN operand 1 in bits 30:0. Opcode 0 with `src1 == src2` correctly boxed returns all 64 bits of `src1` unchanged.
- R8: Opcode 3 (FP to integer) drives `int_wb` with `src1[31:0]` sign-extended to 64 bits. No boxing check is made, and `fp_wb` is zero.
- R9: Opcode 4 (integer to FP) drives `fp_wb` with all ones in bits 63:32 and `src1[31:0]` in bits 31:0, payload unchanged.
- R10: Opcodes 6 and 7 are reserved. A request carrying one gives `out_vld` low and both outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request valid |
| in_op | input | 3 | Operation code (0..5, 6/7 reserved) |
| src1 | input | 64 | First register value (integer value for opcode 4) |
| src2 | input | 64 | Second register value |
| arith_res | input | 32 | Result from the external arithmetic unit |
| out_vld | output | 1 | Result valid, one cycle after request |
| fp_wb | output | 64 | Value for the FP register file |
| int_wb | output | 64 | Value for the integer register file |

## Verification
Two functions can act in the same cycle: operand unboxing and sign injection. One example is an inverted-sign injection whose operand 1 is badly boxed while operand 2 is a negative boxed value. The result must be the canonical NaN body with the sign taken from operand 2, so a correct result needs both functions working. The bench sets up such cases directly, with operand 1 bad, operand 2 bad, and both bad. It also sets them up at random, because about a quarter of the random register values carry a broken upper half. Every result is compared with a model in the bench that unboxes first and then applies the sign rule.

// File: rtl/fpbox_pkg.sv
`timescale 1ns/1ps
package fpbox_pkg;
   typedef enum logic [2:0] {
      FB_SGNJ  = 3'd0,
      FB_SGNJN = 3'd1,
      FB_SGNJX = 3'd2,
      FB_F2X   = 3'd3,
      FB_X2F   = 3'd4,
      FB_ARITH = 3'd5
   } fb_op_e;

   typedef enum logic [1:0] {
      SG_COPY = 2'd0,
      SG_INV  = 2'd1,
      SG_XOR  = 2'd2
   } sg_mode_e;
endpackage

// File: rtl/fpbox_unbox.sv
`timescale 1ns/1ps
module fpbox_unbox #(
   parameter int FLEN = 64,
   parameter int SLEN = 32,
   parameter int EXPW = 8
) (
   input  logic [FLEN-1:0] i_reg,
   output logic [SLEN-1:0] o_val,
   output logic            o_bad
);
   localparam int BOXW = FLEN - SLEN;
   localparam int MANW = SLEN - 1 - EXPW;
   localparam logic [SLEN-1:0] CANON = {1'b0, {EXPW{1'b1}}, 1'b1, {(MANW-1){1'b0}}};

   assign o_bad = (i_reg[FLEN-1:SLEN] != {BOXW{1'b1}});
   assign o_val = o_bad ? CANON : i_reg[SLEN-1:0];
endmodule

// File: rtl/fpbox_sgnj.sv
`timescale 1ns/1ps
module fpbox_sgnj
   import fpbox_pkg::*;
#(
   parameter int SLEN = 32
) (
   input  logic [SLEN-1:0] i_a,
   input  logic [SLEN-1:0] i_b,
   input  logic [1:0]      i_mode,
   output logic [SLEN-1:0] o_y
);
   logic sgn;

   always_comb begin
      case (sg_mode_e'(i_mode))
         SG_COPY: sgn = i_b[SLEN-1];
         SG_INV:  sgn = ~i_b[SLEN-1];
         SG_XOR:  sgn = i_a[SLEN-1] ^ i_b[SLEN-1];
         default: sgn = i_a[SLEN-1];
      endcase
   end

   assign o_y = {sgn, i_a[SLEN-2:0]};
endmodule

// File: rtl/fpbox_canon.sv
`timescale 1ns/1ps
module fpbox_canon #(
   parameter int SLEN = 32,
   parameter int EXPW = 8
) (
   input  logic [SLEN-1:0] i_val,
   output logic [SLEN-1:0] o_val,
   output logic            o_nan
);
   localparam int MANW = SLEN - 1 - EXPW;
   localparam logic [SLEN-1:0] CANON = {1'b0, {EXPW{1'b1}}, 1'b1, {(MANW-1){1'b0}}};

   logic exp_ones;
   logic man_nz;

   assign exp_ones = &i_val[SLEN-2:MANW];
   assign man_nz   = |i_val[MANW-1:0];
   assign o_nan    = exp_ones & man_nz;
   assign o_val    = o_nan ? CANON : i_val;
endmodule

// File: rtl/fp_box_unit.sv
`timescale 1ns/1ps
module fp_box_unit
   import fpbox_pkg::*;
#(
   parameter int FLEN      = 64,
   parameter int SLEN      = 32,
   parameter int EXPW      = 8,
   parameter bit SEXT_MOVE = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_vld,
   input  logic [2:0]      in_op,
   input  logic [FLEN-1:0] src1,
   input  logic [FLEN-1:0] src2,
   input  logic [SLEN-1:0] arith_res,
   output logic            out_vld,
   output logic [FLEN-1:0] fp_wb,
   output logic [FLEN-1:0] int_wb
);
   localparam int BOXW  = FLEN - SLEN;
   localparam int MANW  = SLEN - 1 - EXPW;
   localparam int NSRC  = 2;
   localparam logic [BOXW-1:0] BOX = {BOXW{1'b1}};
   localparam logic [SLEN-1:0] CANON = {1'b0, {EXPW{1'b1}}, 1'b1, {(MANW-1){1'b0}}};

   // elaboration-time parameter checks
   if (FLEN <= SLEN) begin : g_chk_flen
      $error("FLEN must exceed SLEN");
   end
   if (MANW < 2) begin : g_chk_manw
      $error("EXPW leaves no room for a quiet mantissa");
   end

   // operand unboxing, one slice per source
   logic [FLEN-1:0] raw [NSRC];
   logic [SLEN-1:0] unb [NSRC];
   logic [NSRC-1:0] bad;

   assign raw[0] = src1;
   assign raw[1] = src2;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_unbox
      fpbox_unbox #(.FLEN(FLEN), .SLEN(SLEN), .EXPW(EXPW)) u_unbox (
         .i_reg (raw[gi]),
         .o_val (unb[gi]),
         .o_bad (bad[gi])
      );
   end

   logic [SLEN-1:0] sg_res;
   fpbox_sgnj #(.SLEN(SLEN)) u_sgnj (
      .i_a    (unb[0]),
      .i_b    (unb[1]),
      .i_mode (in_op[1:0]),
      .o_y    (sg_res)
   );

   logic [SLEN-1:0] ar_res;
   logic            ar_nan;
   fpbox_canon #(.SLEN(SLEN), .EXPW(EXPW)) u_canon (
      .i_val (arith_res),
      .o_val (ar_res),
      .o_nan (ar_nan)
   );

   // FP to integer extension variant
   logic [FLEN-1:0] mv_ext;
   if (SEXT_MOVE) begin : g_sext
      assign mv_ext = {{BOXW{src1[SLEN-1]}}, src1[SLEN-1:0]};
   end else begin : g_zext
      assign mv_ext = {{BOXW{1'b0}}, src1[SLEN-1:0]};
   end

   logic            nxt_vld;
   logic [FLEN-1:0] nxt_fp;
   logic [FLEN-1:0] nxt_int;

   always_comb begin
      nxt_vld = 1'b0;
      nxt_fp  = '0;
      nxt_int = '0;
      if (in_vld) begin
         case (fb_op_e'(in_op))
            FB_SGNJ, FB_SGNJN, FB_SGNJX: begin
               nxt_vld = 1'b1;
               nxt_fp  = {BOX, sg_res};
            end
            FB_F2X: begin
               nxt_vld = 1'b1;
               nxt_int = mv_ext;
            end
            FB_X2F: begin
               nxt_vld = 1'b1;
               nxt_fp  = {BOX, src1[SLEN-1:0]};
            end
            FB_ARITH: begin
               nxt_vld = 1'b1;
               nxt_fp  = {BOX, ar_res};
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
         fp_wb   <= '0;
         int_wb  <= '0;
      end else begin
         out_vld <= nxt_vld;
         fp_wb   <= nxt_fp;
         int_wb  <= nxt_int;
      end
   end

   // ---------------- assertions ----------------
   a_r1_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (!out_vld && fp_wb == '0 && int_wb == '0));

   a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !$past(in_vld)) |-> (!out_vld && fp_wb == '0 && int_wb == '0));

   a_r5_fp_boxed: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && out_vld && $past(in_op) != 3'd3)
         |-> (fp_wb[FLEN-1:SLEN] == BOX && int_wb == '0));

   a_r6_arith_canon: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(in_vld) && $past(in_op) == 3'd5
         && $past(&arith_res[SLEN-2:MANW]) && $past(|arith_res[MANW-1:0]))
         |-> (fp_wb == {BOX, CANON}));

   a_r7_payload_kept: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(in_vld) && $past(in_op) <= 3'd2
         && $past(src1[FLEN-1:SLEN]) == BOX)
         |-> (fp_wb[SLEN-2:0] == $past(src1[SLEN-2:0])));

   a_r8_move_ext: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(in_vld) && $past(in_op) == 3'd3)
         |-> (out_vld && int_wb[SLEN-1:0] == $past(src1[SLEN-1:0]) && fp_wb == '0));

   a_r10_reserved: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(in_vld) && $past(in_op) >= 3'd6)
         |-> (!out_vld && fp_wb == '0 && int_wb == '0));
endmodule

// File: tb/sim_fp_box_unit.sv
`timescale 1ns/1ps
module sim_fp_box_unit;
   localparam logic [31:0] CN = 32'h7FC00000;
   localparam logic [31:0] ONES = 32'hFFFFFFFF;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [2:0]  in_op = 3'd0;
   logic [63:0] src1 = '0;
   logic [63:0] src2 = '0;
   logic [31:0] arith_res = '0;
   logic        out_vld;
   logic [63:0] fp_wb;
   logic [63:0] int_wb;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fp_box_unit u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
      .src1(src1), .src2(src2), .arith_res(arith_res),
      .out_vld(out_vld), .fp_wb(fp_wb), .int_wb(int_wb)
   );

   function automatic logic [31:0] m_unbox(input logic [63:0] r);
      return (r[63:32] == ONES) ? r[31:0] : CN;
   endfunction

   function automatic void model(input logic v, input logic [2:0] op,
                                 input logic [63:0] a, input logic [63:0] b,
                                 input logic [31:0] ar, output logic ev,
                                 output logic [63:0] ef, output logic [63:0] ei);
      logic [31:0] ua, ub, r;
      logic s;
      ev = 1'b0; ef = '0; ei = '0;
      ua = m_unbox(a); ub = m_unbox(b);
      if (v) begin
         if (op <= 3'd2) begin
            s = (op == 3'd0) ? ub[31] : (op == 3'd1) ? ~ub[31] : (ua[31] ^ ub[31]);
            ev = 1'b1; ef = {ONES, s, ua[30:0]};
         end else if (op == 3'd3) begin
            ev = 1'b1; ei = {{32{a[31]}}, a[31:0]};
         end else if (op == 3'd4) begin
            ev = 1'b1; ef = {ONES, a[31:0]};
         end else if (op == 3'd5) begin
            r = (ar[30:23] == 8'hFF && ar[22:0] != 0) ? CN : ar;
            ev = 1'b1; ef = {ONES, r};
         end
      end
   endfunction

   task automatic check(input string req, input logic ev, input logic [63:0] ef,
                        input logic [63:0] ei);
      n_chk++;
      if (out_vld !== ev || fp_wb !== ef || int_wb !== ei) begin
         n_fail++;
         $display("FAIL %s: got vld=%0b fp=%h int=%h, expected vld=%0b fp=%h int=%h",
                  req, out_vld, fp_wb, int_wb, ev, ef, ei);
      end
   endtask

   task automatic run(input string req, input logic v, input logic [2:0] op,
                      input logic [63:0] a, input logic [63:0] b, input logic [31:0] ar);
      logic ev;
      logic [63:0] ef, ei;
      @(negedge clk);
      in_vld = v; in_op = op; src1 = a; src2 = b; arith_res = ar;
      model(v, op, a, b, ar, ev, ef, ei);
      @(posedge clk);
      #1;
      check(req, ev, ef, ei);
   endtask

   function automatic logic [63:0] rnd_reg();
      logic [63:0] r;
      r = {$urandom, $urandom};
      if ($urandom % 4 != 0) r[63:32] = ONES;
      if ($urandom % 3 == 0) begin
         r[30:23] = 8'hFF;
         if (r[22:0] == 0) r[0] = 1'b1;
      end
      return r;
   endfunction

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd1357);
      rst = 1'b1;
      in_vld = 1'b1; in_op = 3'd4; src1 = '1;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", 1'b0, '0, '0);
      @(negedge clk);
      rst = 1'b0;

      // R2 idle cycles
      run("R2 idle", 1'b0, 3'd0, {ONES, 32'h3F800000}, {ONES, 32'hBF800000}, 32'h1);
      // R4 sign rules with normal values
      run("R4 sgnj", 1'b1, 3'd0, {ONES, 32'h3F800000}, {ONES, 32'hC0000000}, 0);
      run("R4 sgnjn", 1'b1, 3'd1, {ONES, 32'h3F800000}, {ONES, 32'hC0000000}, 0);
      run("R4 sgnjx", 1'b1, 3'd2, {ONES, 32'hBF800000}, {ONES, 32'hC0000000}, 0);
      // R3 bad boxing, alone and combined with sign injection
      run("R3 bad src1 sgnjn", 1'b1, 3'd1, 64'h00000000_3F800000, {ONES, 32'h80000000}, 0);
      run("R3 bad src2 sgnj", 1'b1, 3'd0, {ONES, 32'h3F800000}, 64'hFFFFFFFE_80000000, 0);
      run("R3 both bad sgnjx", 1'b1, 3'd2, 64'h7FFFFFFF_FFFFFFFF, 64'h1, 0);
      // R7 payload kept, exact 64-bit pass
      run("R7 nan payload pass", 1'b1, 3'd0, {ONES, 32'h7F812345}, {ONES, 32'h7F812345}, 0);
      run("R7 payload sgnjn", 1'b1, 3'd1, {ONES, 32'hFFA5A5A5}, {ONES, 32'hFFA5A5A5}, 0);
      // R6 arithmetic path
      run("R6 nan canon", 1'b1, 3'd5, 0, 0, 32'hFF812345);
      run("R6 inf kept", 1'b1, 3'd5, 0, 0, 32'h7F800000);
      run("R6 normal kept", 1'b1, 3'd5, 0, 0, 32'h40490FDB);
      // R8 and R9 moves
      run("R8 f2x neg no check", 1'b1, 3'd3, 64'h12345678_FFC00001, 0, 0);
      run("R8 f2x pos", 1'b1, 3'd3, 64'hFFFFFFFF_7F812345, 0, 0);
      run("R9 x2f payload", 1'b1, 3'd4, 64'h00000000_7F812345, 0, 0);
      // R10 reserved
      run("R10 op6", 1'b1, 3'd6, {ONES, 32'h1}, {ONES, 32'h2}, 32'h3);
      run("R10 op7", 1'b1, 3'd7, {ONES, 32'h1}, {ONES, 32'h2}, 32'h3);
      // R5 and mixed random traffic, back to back
      for (int i = 0; i < 600; i++) begin
         logic [31:0] ar;
         ar = $urandom;
         if ($urandom % 3 == 0) ar[30:23] = 8'hFF;
         run("R5 random", ($urandom % 8) != 0, 3'($urandom % 8), rnd_reg(), rnd_reg(), ar);
      end
      // R1 reset in the middle of traffic
      @(negedge clk);
      in_vld = 1'b1; in_op = 3'd4; src1 = 64'h5; rst = 1'b1;
      @(posedge clk);
      #1;
      check("R1 reset mid", 1'b0, '0, '0);
      @(negedge clk);
      rst = 1'b0;
      run("R2 after reset", 1'b1, 3'd4, 64'h00000000_DEADBEEF, 0, 0);
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got no completion, expected completion");
         summary();
      end
   end
endmodule